// File: doc/BRIEF.md
# Dual-Reload PWM Output Timer

This block produces a pulse-width-modulated output from a 16-bit down counter that is loaded in turn from two reload values. The first value, called reload 0, sets the length of the low phase. The second value, reload 1, sets the length of the high phase. Each time the counter runs out, an underflow occurs. The underflow flips the output level, raises a one-cycle interrupt strobe and reloads the counter from the other reload value. A programmable prescaler sets the count rate: the counter moves once every `prescale_div + 1` clocks.

Software changes the waveform through two write strobes that share one data bus. A reload 1 write goes only into a holding buffer and has no effect on its own. A reload 0 write commits a new pair: the written reload 0 data plus the buffered reload 1 value. The pair becomes active only at the underflow that begins a new low phase, so a period never mixes halves from two different settings. When `enable` is low, the counter and the output are frozen. When `enable` rises, the timer restarts from a defined state.

Top module: `dual_reload_pwm`

## Requirements
- R1: While `rst_n` is low, and after a reset, `pwm_out` is 0, `irq` is 0 and `count` is 0.
- R2: In the clock after the first cycle in which `enable` is high following a low period, `pwm_out` is 0 and `count` holds the committed reload 0 value. The committed value is the pending pair if one is waiting, otherwise the active pair.
- R3: While enabled, `count` drops by exactly one on each count tick, and a tick occurs every `prescale_div + 1` clocks. The low phase therefore lasts (reload0+1)×(prescale_div+1) clocks and the high phase lasts (reload1+1)×(prescale_div+1) clocks.
- R4: On each underflow, `pwm_out` toggles and `irq` is high for that one cycle. The counter reloads with reload 1 when the low phase ends and with reload 0 when the high phase ends. With non-zero reloads and `prescale_div` = 0, a full period carries exactly two separate one-cycle `irq` pulses.
- R5: A pulse on `wr_rld1` alone never changes either phase length.
- R6: A pulse on `wr_rld0` commits the pair {`wr_data`, buffered reload 1}. The period already running finishes on the old pair, and the new pair applies from the next low phase onward.
- R7: A `wr_rld0` pulse in the same clock as the underflow that starts a low phase misses that boundary. The old pair runs one more full period, and the new pair applies one period later.
- R8: A `wr_rld0` pulse with no new `wr_rld1` pulse before it pairs with the reload 1 value that was written last.
- R9: While `enable` is low, `count` and `pwm_out` hold their values and `irq` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run control; a rising level restarts the timer |
| prescale_div | input | 8 | Count tick every prescale_div+1 clocks |
| wr_rld0 | input | 1 | Write strobe: commit reload 0 with buffered reload 1 |
| wr_rld1 | input | 1 | Write strobe: load the reload 1 buffer |
| wr_data | input | 16 | Write data for both strobes |
| pwm_out | output | 1 | PWM output level (low phase first) |
| irq | output | 1 | One-cycle pulse per underflow |
| count | output | 16 | Current counter value |

## Verification
Every internal register leaves a mark at the ports within one period. A wrong active pair shows up as a wrong phase length in the next low or high phase. A pending pair that is applied too early, applied too late or never cleared changes the length of the phase just after the commit boundary. A wrong phase register or reload selection shows up at the next underflow, where the reloaded `count` or the new `pwm_out` level is wrong. A prescaler fault changes every measured phase length by a multiple of its divide ratio.

// File: rtl/pwm_pkg.sv
// Shared types for the dual-reload PWM timer.
// Assumes: phase encoding doubles as the output level (low phase drives 0).
package pwm_pkg;
    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;
endpackage

// File: rtl/pwm_prescaler.sv
// Count-enable generator: emits one tick every div+1 clocks while run is high.
// Assumes: run low clears the divider so a restart begins a full tick interval.
module pwm_prescaler #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    logic [DIV_W-1:0] pre_cnt;

    // Divider counter: wraps at div, held at zero while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_cnt <= '0;
        end else if (!run || pre_cnt == div) begin
            pre_cnt <= '0;
        end else begin
            pre_cnt <= pre_cnt + ONE;
        end
    end

    // Tick when the divider reaches its terminal value.
    always_comb begin
        tick = run && (pre_cnt == div);
    end
endmodule

// File: rtl/pwm_reload_bank.sv
// Reload storage: reload 1 buffer, pending pair, active pair.
// A reload 0 write forms a pending pair with the buffered reload 1 value;
// apply moves a pending pair into the active pair. A write in the same
// clock as apply stays pending for the following apply.
// Assumes: both strobes in one clock commit the older buffer contents.
module pwm_reload_bank #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_r0,
    input  logic         wr_r1,
    input  logic [W-1:0] wr_data,
    input  logic         apply,
    output logic [W-1:0] next_r0,
    output logic [W-1:0] act_r1
);
    logic [W-1:0] buf_r1;
    logic [W-1:0] pend_r0;
    logic [W-1:0] pend_r1;
    logic         pend_vld;
    logic [W-1:0] act_r0;

    // Holding buffer for reload 1 writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_r1 <= '0;
        end else if (wr_r1) begin
            buf_r1 <= wr_data;
        end
    end

    // Pending pair: captured on reload 0 write, consumed on apply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_r0  <= '0;
            pend_r1  <= '0;
            pend_vld <= 1'b0;
        end else if (wr_r0) begin
            pend_r0  <= wr_data;
            pend_r1  <= buf_r1;
            pend_vld <= 1'b1;
        end else if (apply) begin
            pend_vld <= 1'b0;
        end
    end

    // Active pair: updated only at period start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_r0 <= '0;
            act_r1 <= '0;
        end else if (apply && pend_vld) begin
            act_r0 <= pend_r0;
            act_r1 <= pend_r1;
        end
    end

    // Reload 0 value that a period start loads this cycle.
    always_comb begin
        next_r0 = pend_vld ? pend_r0 : act_r0;
    end
endmodule

// File: rtl/pwm_phase_counter.sv
// Down counter with alternating reload and phase (output) flip-flop.
// Underflow = tick while count is zero; it toggles the phase, pulses irq
// and reloads from the opposite reload value.
// Assumes: start and tick never coincide (tick needs a running timer).
module pwm_phase_counter
    import pwm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         tick,
    input  logic [W-1:0] next_r0,
    input  logic [W-1:0] act_r1,
    output logic [W-1:0] count,
    output logic         pwm,
    output logic         irq,
    output logic         boundary
);
    localparam logic [W-1:0] ONE = W'(1);

    phase_e phase;
    logic   underflow;

    // Underflow and period-boundary detection.
    always_comb begin
        underflow = tick && (count == '0);
        boundary  = underflow && (phase == PH_HIGH);
        pwm       = (phase == PH_HIGH);
    end

    // Counter, phase and interrupt strobe registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            phase <= PH_LOW;
            irq   <= 1'b0;
        end else begin
            irq <= underflow;
            if (start) begin
                count <= next_r0;
                phase <= PH_LOW;
            end else if (underflow) begin
                if (phase == PH_LOW) begin
                    count <= act_r1;
                    phase <= PH_HIGH;
                end else begin
                    count <= next_r0;
                    phase <= PH_LOW;
                end
            end else if (tick) begin
                count <= count - ONE;
            end
        end
    end
endmodule

// File: rtl/dual_reload_pwm.sv
// Top of the dual-reload PWM timer: run tracking, prescaler, reload bank
// and phase counter.
// Assumes: enable is synchronous to clk; writes are single-cycle strobes.
module dual_reload_pwm #(
    parameter int CNT_W = 16,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [DIV_W-1:0] prescale_div,
    input  logic             wr_rld0,
    input  logic             wr_rld1,
    input  logic [CNT_W-1:0] wr_data,
    output logic             pwm_out,
    output logic             irq,
    output logic [CNT_W-1:0] count
);
    logic             run_q;
    logic             start;
    logic             run;
    logic             tick;
    logic             boundary;
    logic             apply;
    logic [CNT_W-1:0] next_r0;
    logic [CNT_W-1:0] act_r1;

    // Remembers whether the timer ran last cycle, to find restarts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
        end else begin
            run_q <= enable;
        end
    end

    // Start on an enable rise; pair transfer at start or period boundary.
    always_comb begin
        start = enable && !run_q;
        run   = enable && run_q;
        apply = start || boundary;
    end

    pwm_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .div   (prescale_div),
        .tick  (tick)
    );

    pwm_reload_bank #(.W(CNT_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_r0   (wr_rld0),
        .wr_r1   (wr_rld1),
        .wr_data (wr_data),
        .apply   (apply),
        .next_r0 (next_r0),
        .act_r1  (act_r1)
    );

    pwm_phase_counter #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .tick     (tick),
        .next_r0  (next_r0),
        .act_r1   (act_r1),
        .count    (count),
        .pwm      (pwm_out),
        .irq      (irq),
        .boundary (boundary)
    );
endmodule

// File: rtl/dual_reload_pwm_chk.sv
// Property checker for the dual-reload PWM timer, bound into the top.
module dual_reload_pwm_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             run_q,
    input logic             irq,
    input logic             pwm_out,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] act_r1
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // R4
    toggle_on_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (pwm_out != $past(pwm_out)));

    // R4
    rise_needs_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_out) |-> irq);

    // R4
    high_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && pwm_out) |-> (count == act_r1));

    // R3
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && $past(run_q) && !irq && !$stable(count))
            |-> (count == $past(count) - ONE));

    // R9
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(enable) |-> ($stable(count) && $stable(pwm_out)));

    // R9
    quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(enable) |-> !irq);
endmodule

bind dual_reload_pwm dual_reload_pwm_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .run_q   (run_q),
    .irq     (irq),
    .pwm_out (pwm_out),
    .count   (count),
    .act_r1  (act_r1)
);

// File: tb/dual_reload_pwm_test.sv
`timescale 1ns/1ps
// Directed bench for the dual-reload PWM timer; one task per scenario.
module dual_reload_pwm_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [7:0]  prescale_div = 8'd0;
    logic        wr_rld0 = 1'b0;
    logic        wr_rld1 = 1'b0;
    logic [15:0] wr_data = 16'd0;
    logic        pwm_out;
    logic        irq;
    logic [15:0] count;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dual_reload_pwm uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .prescale_div (prescale_div),
        .wr_rld0      (wr_rld0),
        .wr_rld1      (wr_rld1),
        .wr_data      (wr_data),
        .pwm_out      (pwm_out),
        .irq          (irq),
        .count        (count)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Called at a negedge: one-cycle write strobe, returns at the next negedge.
    task automatic wr(input bit to_r0, input int data);
        wr_data = 16'(data);
        if (to_r0) wr_rld0 = 1'b1; else wr_rld1 = 1'b1;
        @(negedge clk);
        wr_rld0 = 1'b0;
        wr_rld1 = 1'b0;
    endtask

    // Waits until pwm_out changes to lvl (first cycle of that level).
    task automatic sync_to(input logic lvl);
        logic prev;
        prev = pwm_out;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (pwm_out == lvl && prev != lvl) break;
            prev = pwm_out;
        end
    endtask

    // From the first cycle of a level, counts cycles until it changes.
    task automatic phase_len(output int len);
        logic lvl;
        lvl = pwm_out;
        len = 1;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (pwm_out != lvl) break;
            len++;
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "pwm_out in reset", int'(pwm_out), 0);
        chk("R1", "irq in reset", int'(irq), 0);
        chk("R1", "count in reset", int'(count), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_basic();
        int n;
        prescale_div = 8'd0;
        wr(1'b0 == 1'b1, 1);
        wr(1'b1, 3);
        enable = 1'b1;
        @(negedge clk);
        chk("R2", "count after start", int'(count), 3);
        chk("R2", "pwm_out after start", int'(pwm_out), 0);
        phase_len(n); chk("R3", "low phase r0=3", n, 4);
        phase_len(n); chk("R3", "high phase r1=1", n, 2);
        phase_len(n); chk("R3", "second low phase", n, 4);
        phase_len(n); chk("R3", "second high phase", n, 2);
    endtask

    task automatic t_irq();
        int n = 0;
        int back = 0;
        logic prev;
        sync_to(1'b1);
        chk("R4", "irq with rising pwm", int'(irq), 1);
        prev = irq;
        repeat (6) begin
            @(negedge clk);
            if (irq) n++;
            if (irq && prev) back++;
            prev = irq;
        end
        chk("R4", "irq pulses per period", n, 2);
        chk("R4", "back-to-back irq cycles", back, 0);
    endtask

    task automatic t_r1_only();
        int n;
        wr(1'b0, 9);
        sync_to(1'b0);
        phase_len(n); chk("R5", "low after lone r1 write", n, 4);
        phase_len(n); chk("R5", "high after lone r1 write", n, 2);
        phase_len(n); chk("R5", "low later", n, 4);
        phase_len(n); chk("R5", "high later", n, 2);
    endtask

    task automatic t_commit();
        int n;
        sync_to(1'b0);
        @(negedge clk);
        wr(1'b0, 5);
        wr(1'b1, 2);
        sync_to(1'b1);
        phase_len(n); chk("R6", "high of current period keeps old r1", n, 2);
        phase_len(n); chk("R6", "low with new r0=2", n, 3);
        phase_len(n); chk("R6", "high with new r1=5", n, 6);
    endtask

    task automatic t_late();
        int n;
        for (int i = 0; i < 100; i++) begin
            if (pwm_out == 1'b1 && count == 16'd0) break;
            @(negedge clk);
        end
        wr(1'b1, 7);
        phase_len(n); chk("R7", "low at missed boundary stays old", n, 3);
        phase_len(n); chk("R7", "high stays old", n, 6);
        phase_len(n); chk("R7", "low one period later r0=7", n, 8);
        phase_len(n); chk("R7", "high one period later", n, 6);
    endtask

    task automatic t_r0_only();
        int n;
        wr(1'b1, 1);
        sync_to(1'b0);
        phase_len(n); chk("R8", "low with r0=1", n, 2);
        phase_len(n); chk("R8", "high keeps buffered r1=5", n, 6);
    endtask

    task automatic t_freeze_restart();
        int n;
        int bad_cnt = 0;
        int bad_pwm = 0;
        int bad_irq = 0;
        logic [15:0] c;
        logic p;
        sync_to(1'b1);
        @(negedge clk);
        enable = 1'b0;
        c = count;
        p = pwm_out;
        repeat (8) begin
            @(negedge clk);
            if (count != c) bad_cnt++;
            if (pwm_out != p) bad_pwm++;
            if (irq) bad_irq++;
        end
        chk("R9", "count changes while disabled", bad_cnt, 0);
        chk("R9", "pwm changes while disabled", bad_pwm, 0);
        chk("R9", "irq cycles while disabled", bad_irq, 0);
        chk("R9", "frozen level was high", int'(p), 1);
        enable = 1'b1;
        @(negedge clk);
        chk("R2", "count after restart", int'(count), 1);
        chk("R2", "pwm_out low after restart", int'(pwm_out), 0);
        phase_len(n); chk("R3", "first low after restart", n, 2);
    endtask

    task automatic t_prescale();
        int n;
        enable = 1'b0;
        prescale_div = 8'd2;
        @(negedge clk);
        wr(1'b0, 0);
        wr(1'b1, 1);
        enable = 1'b1;
        @(negedge clk);
        chk("R2", "count after start with pending pair", int'(count), 1);
        sync_to(1'b1);
        phase_len(n); chk("R3", "high r1=0 div=2", n, 3);
        phase_len(n); chk("R3", "low r0=1 div=2", n, 6);
        phase_len(n); chk("R3", "high again div=2", n, 3);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_basic();
        t_irq();
        t_r1_only();
        t_commit();
        t_late();
        t_r0_only();
        t_freeze_restart();
        t_prescale();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule